// File: doc/BRIEF.md
# Debug Instruction Transfer Issue Unit

This unit sits between a JTAG-style debug test access port and a processor core that is halted for debug. It owns a 32-bit instruction holding register. A debugger loads that register through a dedicated data scan chain. Each time the TAP controller enters Run-Test/Idle, the unit decides whether to hand the held word to the core. When it does, it raises a one-cycle issue strobe and drives the instruction word alongside it.

The held word is not consumed when it is issued. A debugger can therefore execute the same instruction many times by cycling the TAP through Run-Test/Idle, with no rescan. Issue and loading are both gated by several conditions:

- an execute-enable control bit,
- an internal core-ready flag, which the unit clears on issue and the core sets again when it finishes,
- a sticky abort flag.

The TAP state machine, the core and the data transfer path are outside the block.

Top module: `dbg_instr_issue`

## Requirements
- R1: After reset, `issue_valid` is 0, `core_ready` is 1 and `issue_instr` is 0.
- R2: The register is reached when `ir_code` holds INTEST (4'b1100) or EXTEST (4'b0000) and `chain_sel` is 4. Capture-DR (4'h6) copies the held word into the shift stage. Each Shift-DR (4'h2) cycle presents bit 0 on `tdo` first and moves `tdi` into bit 31. Update-DR (4'h5) commits the shift stage to `issue_instr`.
- R3: `issue_instr` changes only on an Update-DR cycle with chain 4 selected. A scan through any other chain, including chain 5, leaves it unchanged.
- R4: The unit gives exactly one `issue_valid` pulse per entry into Run-Test/Idle (4'hC), however long the TAP stays there. The pulse appears in the cycle after the first Run-Test/Idle cycle.
- R5: Issue happens only while `ir_code` is INTEST or EXTEST and `chain_sel` is 4 or 5. Any other IR code or chain gives no pulse.
- R6: When `exec_en` is 0, entering Run-Test/Idle issues nothing. While `exec_en` is 0, loads are not gated by ready or abort.
- R7: An issue clears `core_ready`. A one-cycle `core_done` sets it again. While `core_ready` is 0 with `in_debug` and `exec_en` set, no issue and no commit take place.
- R8: While `sticky_abort` is 1 with `in_debug` and `exec_en` set, no issue and no commit take place.
- R9: The held word survives issue. Each later entry into Run-Test/Idle with all conditions met issues the same word again.
- R10: When `exec_en` is 1 while `in_debug` is 0, `misuse_flag` is 1 and no issue takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TAP-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tap_state | input | 4 | Current TAP controller state code |
| ir_code | input | 4 | Current TAP instruction register value |
| chain_sel | input | 5 | Selected scan chain number |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output (bit 0 of the shift stage) |
| in_debug | input | 1 | Core is halted in debug state |
| exec_en | input | 1 | Execute-instruction enable control bit |
| core_done | input | 1 | Core finished the issued instruction |
| sticky_abort | input | 1 | Sticky precise data abort flag |
| issue_valid | output | 1 | One-cycle instruction issue strobe |
| issue_instr | output | 32 | Held instruction word |
| core_ready | output | 1 | Ready flag for the next issue or load |
| misuse_flag | output | 1 | Enable set while the core is not in debug state |

## Verification
The bench stays in Run-Test/Idle for several cycles. A design that pulsed on every cycle in that state, rather than once per entry, would show extra strobes. It rescans while ready is low and while the abort flag is high. A design that committed regardless would change the held word, and one that ignored either gate on issue would strobe when it must stay silent. Scans through chain 5 and passes with a wrong IR code or chain catch loose chain and IR decoding. The word shifted out during each scan must equal the previous load with bit 0 first, so a reversed shift order or a missing capture would show up at once.

// File: rtl/dbg_instr_issue.sv
module dbg_instr_issue #(
  parameter int IW        = 32,
  parameter int IRW       = 4,
  parameter int CHW       = 5,
  parameter int SW        = 4,
  parameter logic [SW-1:0]  ST_TLR   = 4'hF,
  parameter logic [SW-1:0]  ST_RTI   = 4'hC,
  parameter logic [SW-1:0]  ST_CAPDR = 4'h6,
  parameter logic [SW-1:0]  ST_SHDR  = 4'h2,
  parameter logic [SW-1:0]  ST_UPDDR = 4'h5,
  parameter logic [IRW-1:0] IR_INT   = 4'b1100,
  parameter logic [IRW-1:0] IR_EXT   = 4'b0000,
  parameter logic [CHW-1:0] CH_LOAD  = 5'd4,
  parameter logic [CHW-1:0] CH_ALT   = 5'd5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SW-1:0]  tap_state,
  input  logic [IRW-1:0] ir_code,
  input  logic [CHW-1:0] chain_sel,
  input  logic           tdi,
  output logic           tdo,
  input  logic           in_debug,
  input  logic           exec_en,
  input  logic           core_done,
  input  logic           sticky_abort,
  output logic           issue_valid,
  output logic [IW-1:0]  issue_instr,
  output logic           core_ready,
  output logic           misuse_flag
);

  logic [SW-1:0] prev_state;
  logic [IW-1:0] shreg;
  logic [IW-1:0] held;
  logic          ready_q;
  logic          valid_q;

  wire ir_ok     = (ir_code == IR_INT) || (ir_code == IR_EXT);
  wire load_path = ir_ok && (chain_sel == CH_LOAD);
  wire issue_ch  = (chain_sel == CH_LOAD) || (chain_sel == CH_ALT);
  wire gated     = in_debug && exec_en;
  wire gate_ok   = ready_q && !sticky_abort;
  wire load_ok   = !gated || gate_ok;
  wire rti_entry = (tap_state == ST_RTI) && (prev_state != ST_RTI);
  wire do_issue  = rti_entry && ir_ok && issue_ch && gated && gate_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_state <= ST_TLR;
    else        prev_state <= tap_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else if (load_path && tap_state == ST_CAPDR) shreg <= held;
    else if (load_path && tap_state == ST_SHDR)  shreg <= {tdi, shreg[IW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else if (load_path && tap_state == ST_UPDDR && load_ok) held <= shreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      valid_q <= do_issue;
      if (do_issue)       ready_q <= 1'b0;
      else if (core_done) ready_q <= 1'b1;
    end
  end

  assign tdo         = shreg[0];
  assign issue_valid = valid_q;
  assign issue_instr = held;
  assign core_ready  = ready_q;
  assign misuse_flag = exec_en && !in_debug;

  a_r4_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !issue_valid);
  a_r4_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ($past(tap_state) == ST_RTI) && ($past(prev_state) != ST_RTI));
  a_r7_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !core_ready);
  a_r6_enable: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> $past(exec_en) && $past(in_debug));
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !$past(sticky_abort));
  a_r5_chain: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ($past(chain_sel) == CH_LOAD) || ($past(chain_sel) == CH_ALT));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_state != ST_UPDDR) |=> $stable(issue_instr));

endmodule

// File: tb/dbg_instr_issue_bench.sv
module dbg_instr_issue_bench;
  localparam logic [3:0] TLR = 4'hF, RTI = 4'hC, SELDR = 4'h7, CAPDR = 4'h6,
                         SHDR = 4'h2, EX1DR = 4'h1, UPDDR = 4'h5;
  localparam logic [3:0] INTEST = 4'b1100, EXTEST = 4'b0000;

  logic clk = 0, rst_n = 0;
  logic [3:0] tap_state = TLR, ir_code = INTEST;
  logic [4:0] chain_sel = 5'd4;
  logic tdi = 0, in_debug = 1, exec_en = 0, core_done = 0, sticky_abort = 0;
  logic tdo, issue_valid, core_ready, misuse_flag;
  logic [31:0] issue_instr;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dbg_instr_issue u_dbg_instr_issue (
    .clk(clk), .rst_n(rst_n), .tap_state(tap_state), .ir_code(ir_code),
    .chain_sel(chain_sel), .tdi(tdi), .tdo(tdo), .in_debug(in_debug),
    .exec_en(exec_en), .core_done(core_done), .sticky_abort(sticky_abort),
    .issue_valid(issue_valid), .issue_instr(issue_instr),
    .core_ready(core_ready), .misuse_flag(misuse_flag));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] st);
    tap_state = st;
    @(negedge clk);
  endtask

  task automatic scan(input logic [31:0] val, output logic [31:0] seen);
    step(SELDR);
    step(CAPDR);
    for (int i = 0; i < 32; i++) begin
      tap_state = SHDR;
      tdi = val[i];
      #0.5 seen[i] = tdo;
      @(negedge clk);
    end
    step(EX1DR);
    step(UPDDR);
    step(SELDR);
  endtask

  task automatic rti_pass(input int dwell, output int pulses);
    pulses = 0;
    step(SELDR);
    for (int i = 0; i < dwell; i++) begin
      step(RTI);
      if (issue_valid) pulses++;
    end
    step(SELDR);
    if (issue_valid) pulses++;
  endtask

  task automatic done_pulse();
    core_done = 1;
    @(negedge clk);
    core_done = 0;
  endtask

  task automatic t_reset();
    check("R1 issue_valid", issue_valid, 0);
    check("R1 core_ready", core_ready, 1);
    check("R1 issue_instr", issue_instr, 0);
  endtask

  task automatic t_load();
    logic [31:0] seen;
    scan(32'hE1A0_1234, seen);
    check("R2 shift-out of reset word", seen, 32'h0);
    check("R2 commit", issue_instr, 32'hE1A0_1234);
    scan(32'h5A5A_C3C1, seen);
    check("R2 LSB-first shift-out", seen, 32'hE1A0_1234);
    check("R2 second commit", issue_instr, 32'h5A5A_C3C1);
  endtask

  task automatic t_noexec();
    int p;
    exec_en = 0;
    rti_pass(4, p);
    check("R6 no issue with enable clear", p, 0);
  endtask

  task automatic t_issue();
    int p;
    exec_en = 1;
    rti_pass(6, p);
    check("R4 single pulse over long dwell", p, 1);
    check("R9 issued word", issue_instr, 32'h5A5A_C3C1);
    check("R7 ready cleared", core_ready, 0);
  endtask

  task automatic t_ready();
    int p;
    logic [31:0] seen;
    rti_pass(3, p);
    check("R7 no issue while not ready", p, 0);
    scan(32'h1111_2222, seen);
    check("R7 no commit while not ready", issue_instr, 32'h5A5A_C3C1);
    done_pulse();
    check("R7 ready restored", core_ready, 1);
    rti_pass(2, p);
    check("R9 re-issue without rescan", p, 1);
    check("R9 same word", issue_instr, 32'h5A5A_C3C1);
    done_pulse();
  endtask

  task automatic t_chain();
    int p;
    logic [31:0] seen;
    chain_sel = 5'd5;
    rti_pass(2, p);
    check("R5 chain 5 issues", p, 1);
    done_pulse();
    chain_sel = 5'd3;
    rti_pass(2, p);
    check("R5 chain 3 no issue", p, 0);
    chain_sel = 5'd5;
    scan(32'hDEAD_BEEF, seen);
    check("R3 chain 5 scan leaves word", issue_instr, 32'h5A5A_C3C1);
    chain_sel = 5'd4;
    ir_code = EXTEST;
    rti_pass(2, p);
    check("R5 EXTEST issues", p, 1);
    done_pulse();
    ir_code = 4'hA;
    rti_pass(2, p);
    check("R5 other IR no issue", p, 0);
    ir_code = INTEST;
  endtask

  task automatic t_abort();
    int p;
    logic [31:0] seen;
    sticky_abort = 1;
    rti_pass(2, p);
    check("R8 abort blocks issue", p, 0);
    scan(32'h0BAD_0BAD, seen);
    check("R8 abort blocks commit", issue_instr, 32'h5A5A_C3C1);
    sticky_abort = 0;
    rti_pass(2, p);
    check("R8 issue after abort clear", p, 1);
    done_pulse();
  endtask

  task automatic t_misuse();
    int p;
    in_debug = 0;
    exec_en = 1;
    #0.5 check("R10 misuse flag set", misuse_flag, 1);
    rti_pass(2, p);
    check("R10 no issue outside debug", p, 0);
    in_debug = 1;
    #0.5 check("R10 misuse flag clear", misuse_flag, 0);
  endtask

  task automatic t_free_load();
    logic [31:0] seen;
    exec_en = 0;
    sticky_abort = 1;
    scan(32'hCAFE_F00D, seen);
    check("R6 load ungated with enable clear", issue_instr, 32'hCAFE_F00D);
    sticky_abort = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load();
    t_noexec();
    t_issue();
    t_ready();
    t_chain();
    t_abort();
    t_misuse();
    t_free_load();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule